// File: doc/BRIEF.md
# I2C Slave Address Matcher with Receive/Transmit Mode Selection

This block is the target side of a two-wire serial bus port. It oversamples the clock and data lines with the system clock, detects bus START and STOP events, and shifts in the first byte after every START. The upper seven bits of that byte are compared with a programmable own address. An all-zero byte, the general-call address, is also accepted. When the address is accepted, the block acknowledges it on the ninth clock. It then stays in receive mode or switches to transmit mode, as chosen by the lowest bit of the address byte.

In receive mode, each data byte from the bus controller is acknowledged and handed to the host logic as a one-cycle strobe. In transmit mode, the block drives a host-supplied byte out most significant bit first. It continues with a new byte for as long as the controller acknowledges. A STOP returns the block to its idle receive state, and a repeated START begins a new address phase. The block has no master function, no 10-bit addressing and no clock stretching.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset and after every STOP (SDA rising while SCL is high), the block is idle in receive mode: `tx_mode`=0, `addressed`=0, `gc_hit`=0 and `sda_oe`=0 (SDA released).
- R2: An address byte whose bits 7:1 equal `own_addr` is acknowledged: `sda_oe`=1 pulls SDA low during the ninth SCL pulse, and `addressed` becomes 1.
- R3: The address byte 00h (general call) is acknowledged and sets `gc_hit`=1, which stays set until the next START or STOP. The byte 01h is not a general call and matches only when `own_addr` is 0.
- R4: A non-matching address byte gets no acknowledge. All later bytes up to the next START or STOP are ignored: SDA stays released and no `rx_valid` pulse occurs.
- R5: When the address byte has bit 0 = 0, the block stays in receive mode. Each following data byte (first bit on the bus = bit 7) is acknowledged and presented on `rx_data` with a one-cycle `rx_valid` pulse.
- R6: When the address byte has bit 0 = 1, `tx_mode` becomes 1. `tx_data` is latched at the end of the acknowledge clock, with a one-cycle `tx_taken` pulse, and is shifted out bit 7 first.
- R7: In transmit mode, a controller acknowledge (SDA low on the ninth clock) makes the block latch and send the next `tx_data` byte. A not-acknowledge ends the transmission, and SDA stays released until the next START or STOP.
- R8: A START that occurs in the middle of a transfer (a repeated START: SDA falling while SCL is high) abandons the current transfer and restarts address reception.
- R9: START and STOP are detected only as SDA edges while SCL is high, after synchronisation of both lines to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| own_addr | input | 7 | Programmed 7-bit own address |
| tx_data | input | 8 | Byte to send in transmit mode |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe, `rx_data` is new |
| tx_taken | output | 1 | One-cycle strobe, `tx_data` was latched |
| tx_mode | output | 1 | 1 = transmit mode, 0 = receive mode |
| gc_hit | output | 1 | Current selection came from the general-call address |
| addressed | output | 1 | Block has been selected since the last START |

## Verification
Some rules are checked by the assertions on every cycle:
- a STOP always leaves SDA released and the block in receive mode;
- SDA is only ever pulled low while the block is selected;
- receive strobes are single-cycle and never occur in transmit mode;
- a transmit latch never happens in receive mode;
- a general-call selection is never a transmit selection.

The directed scenarios show the rest: which address values earn an acknowledge, the bit order of bytes in both directions, the effect of a controller not-acknowledge, and the restart of address decoding on a repeated START.

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 7,
  localparam int BYTE_W     = ADDR_W + 1,
  localparam int CNT_W      = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_taken,
  output logic              tx_mode,
  output logic              gc_hit,
  output logic              addressed
);
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK, S_SKIP
  } st_t;

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic                   scl_d, sda_d;
  st_t                    state;
  logic [CNT_W-1:0]       cnt;
  logic [BYTE_W-1:0]      sh;
  logic                   m_ack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sy[SYNC_STAGES-1];
      sda_d  <= sda_sy[SYNC_STAGES-1];
    end

  wire scl_s     = scl_sy[SYNC_STAGES-1];
  wire sda_s     = sda_sy[SYNC_STAGES-1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  wire byte_end  = scl_fall && (cnt == FULL);
  wire addr_ok   = (sh[BYTE_W-1:1] == own_addr) || (sh == '0);
  wire [BYTE_W-1:0] sh_in = {sh[BYTE_W-2:0], sda_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      sh        <= '0;
      m_ack     <= 1'b0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      tx_taken  <= 1'b0;
      tx_mode   <= 1'b0;
      gc_hit    <= 1'b0;
      addressed <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      tx_taken <= 1'b0;
      if (stop_det || start_det) begin
        state     <= stop_det ? S_IDLE : S_ADDR;
        cnt       <= '0;
        tx_mode   <= 1'b0;
        gc_hit    <= 1'b0;
        addressed <= 1'b0;
      end else begin
        unique case (state)
          S_ADDR: begin
            if (scl_rise) begin
              sh  <= sh_in;
              cnt <= cnt + 1'b1;
            end
            if (byte_end) begin
              if (addr_ok) begin
                state     <= S_AACK;
                addressed <= 1'b1;
                gc_hit    <= (sh == '0);
                tx_mode   <= sh[0];
              end else begin
                state <= S_SKIP;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (tx_mode) begin
              sh       <= tx_data;
              tx_taken <= 1'b1;
              state    <= S_TX;
            end else begin
              state <= S_RX;
            end
          end
          S_RX: begin
            if (scl_rise) begin
              sh  <= sh_in;
              cnt <= cnt + 1'b1;
            end
            if (byte_end) begin
              rx_data  <= sh;
              rx_valid <= 1'b1;
              state    <= S_RACK;
            end
          end
          S_RACK: if (scl_fall) begin
            cnt   <= '0;
            state <= S_RX;
          end
          S_TX: begin
            if (scl_rise) cnt <= cnt + 1'b1;
            if (scl_fall) begin
              if (cnt == FULL) state <= S_TACK;
              else             sh    <= sh << 1;
            end
          end
          S_TACK: begin
            if (scl_rise) m_ack <= ~sda_s;
            if (scl_fall) begin
              if (m_ack) begin
                sh       <= tx_data;
                tx_taken <= 1'b1;
                cnt      <= '0;
                state    <= S_TX;
              end else begin
                state <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end

  assign sda_oe = (state == S_AACK) || (state == S_RACK) ||
                  ((state == S_TX) && !sh[BYTE_W-1]);
endmodule

module i2c_addr_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic rx_valid,
  input logic tx_taken,
  input logic tx_mode,
  input logic gc_hit,
  input logic addressed,
  input logic stop_seen
);
  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (!sda_oe && !tx_mode && !addressed));
  // R4
  drive_only_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> addressed);
  // R5
  rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  // R5
  rx_not_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !tx_mode);
  // R6
  load_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_taken |-> tx_mode);
  // R3
  gc_is_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gc_hit |-> !tx_mode);
endmodule

bind i2c_addr_slave i2c_addr_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .rx_valid(rx_valid),
  .tx_taken(tx_taken), .tx_mode(tx_mode), .gc_hit(gc_hit),
  .addressed(addressed), .stop_seen(stop_det)
);

// File: tb/i2c_addr_slave_tb.sv
`timescale 1ns/1ps
module i2c_addr_slave_tb_top;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic sda_oe, rx_valid, tx_taken, tx_mode, gc_hit, addressed;
  logic [7:0] rx_data;
  wire bus_sda = m_sda & ~sda_oe;

  int n_chk = 0, n_fail = 0, rx_cnt = 0, tk_cnt = 0;
  logic [7:0] rx_last = 8'h00;

  always #2.5 clk = ~clk;

  i2c_addr_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
    .own_addr(OWN), .tx_data(tx_data), .sda_oe(sda_oe),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_taken(tx_taken),
    .tx_mode(tx_mode), .gc_hit(gc_hit), .addressed(addressed)
  );

  always @(posedge clk) begin
    if (rx_valid) begin rx_cnt <= rx_cnt + 1; rx_last <= rx_data; end
    if (tx_taken) tk_cnt <= tk_cnt + 1;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    m_sda = b; wq(); m_scl = 1'b1; wq(); s = bus_sda; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(v[i], s);
    bit_xfer(1'b1, s);
    acked = !s;
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_xfer(1'b1, s); v[i] = s; end
    bit_xfer(!give_ack, s);
  endtask

  task automatic t_reset();
    check(!sda_oe && !tx_mode && !addressed && !gc_hit && !rx_valid, "R1 reset",
          {sda_oe, tx_mode, addressed, gc_hit}, 0);
  endtask

  task automatic t_write();
    logic a; int c0 = rx_cnt;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    check(a, "R2 own address ack", a, 1);
    check(addressed && !tx_mode, "R5 stays receive", {addressed, tx_mode}, 2'b10);
    send_byte(8'hA5, a);
    check(a && rx_last == 8'hA5, "R5 byte A5", rx_last, 8'hA5);
    send_byte(8'h3C, a);
    check(a && rx_last == 8'h3C, "R5 byte 3C", rx_last, 8'h3C);
    check(rx_cnt == c0 + 2, "R5 strobe count", rx_cnt - c0, 2);
    bus_stop(); wq();
    check(!addressed && !tx_mode && !sda_oe, "R1 after stop", {addressed, tx_mode, sda_oe}, 0);
  endtask

  task automatic t_mismatch();
    logic a; int c0 = rx_cnt;
    bus_start();
    send_byte({7'h21, 1'b0}, a);
    check(!a, "R4 no ack for other address", a, 0);
    send_byte(8'h00, a);
    check(!a && rx_cnt == c0, "R4 data ignored", rx_cnt - c0, 0);
    bus_stop(); wq();
  endtask

  task automatic t_gcall();
    logic a;
    bus_start();
    send_byte(8'h00, a);
    check(a && gc_hit, "R3 general call ack", {a, gc_hit}, 2'b11);
    send_byte(8'h77, a);
    check(a && rx_last == 8'h77, "R3 general call data", rx_last, 8'h77);
    bus_stop(); wq();
    check(!gc_hit, "R1 gc cleared by stop", gc_hit, 0);
    bus_start();
    send_byte(8'h01, a);
    check(!a && !gc_hit, "R3 01h not general call", {a, gc_hit}, 0);
    bus_stop(); wq();
  endtask

  task automatic t_read();
    logic a; logic [7:0] v; int k0 = tk_cnt;
    tx_data = 8'hC3;
    bus_start();
    send_byte({OWN, 1'b1}, a);
    check(a && tx_mode, "R6 read address enters transmit", {a, tx_mode}, 2'b11);
    for (int i = 7; i >= 0; i--) begin
      logic s; bit_xfer(1'b1, s); v[i] = s;
    end
    tx_data = 8'h18;
    bit_xfer(1'b0, a);
    check(v == 8'hC3, "R6 first byte", v, 8'hC3);
    get_byte(1'b0, v);
    check(v == 8'h18, "R7 byte after ack", v, 8'h18);
    check(tk_cnt == k0 + 2, "R6 load strobes", tk_cnt - k0, 2);
    wq();
    check(!sda_oe, "R7 released after nack", sda_oe, 0);
    tx_data = 8'h00;
    get_byte(1'b0, v);
    check(v == 8'hFF && tk_cnt == k0 + 2, "R7 no drive after nack", v, 8'hFF);
    check(tx_mode, "R6 mode held until stop", tx_mode, 1);
    bus_stop(); wq();
    check(!tx_mode, "R1 receive after stop", tx_mode, 0);
  endtask

  task automatic t_restart();
    logic a; logic [7:0] v;
    bus_start();
    send_byte({OWN, 1'b0}, a);
    send_byte(8'h11, a);
    check(rx_last == 8'h11, "R8 before restart", rx_last, 8'h11);
    bus_start();
    check(!addressed, "R8 restart drops selection", addressed, 0);
    send_byte({7'h22, 1'b0}, a);
    check(!a, "R8 restart decodes new address", a, 0);
    bus_start();
    tx_data = 8'h96;
    send_byte({OWN, 1'b1}, a);
    check(a && tx_mode, "R9 restart after ignore", {a, tx_mode}, 2'b11);
    get_byte(1'b0, v);
    check(v == 8'h96, "R8 read after restart", v, 8'h96);
    bus_stop(); wq();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_mismatch();
    t_gcall();
    t_read();
    t_restart();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule